// File: doc/BRIEF.md
# Ones-Density Loss-of-Signal Detector

This block watches recovered dual-rail receive data, one bit per recovered-clock cycle, and decides when the line has gone quiet. A bit counts as a one when either rail is high. A long unbroken run of zeros raises a digital alarm. That alarm falls only once a sliding 32-bit window of recent bits holds enough ones. Setting and clearing therefore use two different tests, and the gap between them gives hysteresis.

The digital alarm is ORed with an external analog loss input to form the combined loss-of-signal output. That output is registered. Once it rises it stays high for a minimum number of cycles, so that slow logic downstream can see even a one-cycle analog event. Everything runs on the recovered clock, and the analog input is taken as already synchronous to it.

Top module: `ones_density_los`

## Requirements
- R1: A received bit is a one when `pos_in` or `neg_in` (or both) is high. It is a zero only when both are low.
- R2: `digital_los` rises on the clock edge that samples the ZERO_RUN-th consecutive zero (default 160). It is still low after ZERO_RUN-1 zeros.
- R3: Any received one restarts the zero run. Two runs of ZERO_RUN-1 zeros split by a single one do not raise `digital_los`.
- R4: While `digital_los` is high, it falls on the edge at which the last WIN bits (default 32), including the bit just sampled, hold at least ONES_CLR ones (default 10). Nine ones in the window keep it high.
- R5: `rlos` goes high on the edge after a cycle in which `digital_los` or `analog_los` is high. It stays high while either source is high.
- R6: After each low-to-high transition, `rlos` stays high for at least MIN_W cycles (default 32). A one-cycle analog pulse gives exactly MIN_W high cycles. `rlos` then falls on the first edge at which that time has expired and both sources are low.
- R7: A synchronous active-high `rst` clears the window, the counters and both alarms. `digital_los` and `rlos` read 0 after reset.
- R8: The zero-run counter saturates. An arbitrarily long run of zeros (2000 bits) keeps `digital_los` high without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered clock |
| rst | input | 1 | Synchronous active-high reset |
| pos_in | input | 1 | Positive-rail data bit |
| neg_in | input | 1 | Negative-rail data bit |
| analog_los | input | 1 | External analog loss indication, synchronous to `clk` |
| digital_los | output | 1 | Ones-density alarm |
| rlos | output | 1 | Combined, width-stretched loss-of-signal output |

## Verification
`digital_los` changes on the same edge that samples the deciding bit. It is therefore due one cycle after the bit is driven. `rlos` adds one more register, so it is due two cycles after a data bit and one cycle after an analog level. The bench drives inputs on the falling edge and updates its reference model once for each rising edge. It compares both outputs on the next falling edge, so each comparison lines up with the register count above. Directed sequences hit the exact threshold, window and minimum-width cycles, and a seeded random run with varied ones densities covers the rest.

// File: rtl/los_pkg.sv
package los_pkg;

  // Next value of a saturating zero-run counter.
  function automatic int unsigned run_next(int unsigned run, logic one_bit,
                                           int unsigned limit);
    if (one_bit) return 0;
    if (run >= limit) return limit;
    return run + 1;
  endfunction

  // Next ones count for a sliding window: add the entering bit, drop the leaving bit.
  function automatic int unsigned window_next(int unsigned cnt, logic in_bit,
                                              logic out_bit);
    return cnt + (in_bit ? 1 : 0) - (out_bit ? 1 : 0);
  endfunction

  // Next alarm state: set on the zero run, clear on ones density.
  function automatic logic alarm_next(logic alarm, int unsigned ones,
                                      int unsigned run, int unsigned clr_ones,
                                      int unsigned set_run);
    if (alarm) return !(ones >= clr_ones);
    return run >= set_run;
  endfunction

endpackage

// File: rtl/zero_run_counter.sv
module zero_run_counter #(
  parameter int LIMIT = 160,
  localparam int ZW = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          one_bit,
  output logic [ZW-1:0] run_cnt,
  output logic [ZW-1:0] run_d
);
  import los_pkg::*;

  assign run_d = ZW'(run_next(32'(run_cnt), one_bit, LIMIT));

  always_ff @(posedge clk) begin
    if (rst) run_cnt <= '0;
    else     run_cnt <= run_d;
  end

  a_r3_one_clears_run: assert property (@(posedge clk) disable iff (rst)
    one_bit |=> run_cnt == '0);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    32'(run_cnt) <= LIMIT);
endmodule

// File: rtl/density_window.sv
module density_window #(
  parameter int WIN = 32,
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          one_bit,
  output logic [CW-1:0] ones_cnt,
  output logic [CW-1:0] ones_d
);
  import los_pkg::*;

  logic [WIN-1:0] hist;
  logic           leaving;

  assign leaving = hist[WIN-1];
  assign ones_d  = CW'(window_next(32'(ones_cnt), one_bit, leaving));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= '0;
      ones_cnt <= '0;
    end else begin
      hist     <= {hist[WIN-2:0], one_bit};
      ones_cnt <= ones_d;
    end
  end

  a_r4_count_matches_window: assert property (@(posedge clk) disable iff (rst)
    32'(ones_cnt) == $countones(hist));
endmodule

// File: rtl/min_width_hold.sv
module min_width_hold #(
  parameter int MIN_W = 32,
  localparam int HW = $clog2(MIN_W) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_los,
  output logic rlos
);
  logic [HW-1:0] hold_cnt;
  logic          rise_evt;
  logic          expired;
  logic [HW-1:0] hi_len;

  assign rise_evt = raw_los && !rlos;
  assign expired  = (hold_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rlos     <= 1'b0;
      hold_cnt <= '0;
    end else if (rise_evt) begin
      rlos     <= 1'b1;
      hold_cnt <= HW'(MIN_W - 1);
    end else if (rlos) begin
      if (!expired) hold_cnt <= hold_cnt - 1'b1;
      rlos <= !(expired && !raw_los);
    end
  end

  // Separate high-time counter kept only for the width check.
  always_ff @(posedge clk) begin
    if (rst)                        hi_len <= '0;
    else if (!rlos)                 hi_len <= '0;
    else if (32'(hi_len) < MIN_W)   hi_len <= hi_len + 1'b1;
  end

  a_r5_follows_sources: assert property (@(posedge clk) disable iff (rst)
    raw_los |=> rlos);

  a_r6_min_width: assert property (@(posedge clk) disable iff (rst)
    $fell(rlos) |-> 32'(hi_len) >= MIN_W);
endmodule

// File: rtl/ones_density_los.sv
module ones_density_los #(
  parameter int ZERO_RUN = 160,
  parameter int WIN      = 32,
  parameter int ONES_CLR = 10,
  parameter int MIN_W    = 32,
  localparam int ZW = $clog2(ZERO_RUN + 1),
  localparam int CW = $clog2(WIN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pos_in,
  input  logic neg_in,
  input  logic analog_los,
  output logic digital_los,
  output logic rlos
);
  import los_pkg::*;

  logic          one_bit;
  logic [ZW-1:0] run_cnt, run_d;
  logic [CW-1:0] ones_cnt, ones_d;
  logic          dig_q, dig_d;
  logic          raw_los;

  assign one_bit = pos_in | neg_in;

  zero_run_counter #(.LIMIT(ZERO_RUN)) u_run (
    .clk(clk), .rst(rst), .one_bit(one_bit), .run_cnt(run_cnt), .run_d(run_d)
  );

  density_window #(.WIN(WIN)) u_win (
    .clk(clk), .rst(rst), .one_bit(one_bit), .ones_cnt(ones_cnt), .ones_d(ones_d)
  );

  assign dig_d = alarm_next(dig_q, 32'(ones_d), 32'(run_d), ONES_CLR, ZERO_RUN);

  always_ff @(posedge clk) begin
    if (rst) dig_q <= 1'b0;
    else     dig_q <= dig_d;
  end

  assign raw_los     = dig_q | analog_los;
  assign digital_los = dig_q;

  min_width_hold #(.MIN_W(MIN_W)) u_hold (
    .clk(clk), .rst(rst), .raw_los(raw_los), .rlos(rlos)
  );

  a_r2_set_at_threshold: assert property (@(posedge clk) disable iff (rst)
    $rose(dig_q) |-> 32'(run_cnt) == ZERO_RUN);

  a_r4_clear_needs_density: assert property (@(posedge clk) disable iff (rst)
    $fell(dig_q) |-> 32'(ones_cnt) >= ONES_CLR);
endmodule

// File: tb/ones_density_los_bench.sv
module ones_density_los_bench;
  localparam int ZT = 160;
  localparam int WN = 32;
  localparam int OC = 10;
  localparam int MW = 32;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic pos_in = 1'b0, neg_in = 1'b0, analog_los = 1'b0;
  logic digital_los, rlos;

  int checks = 0, errors = 0, cyc = 0;

  // reference model state
  int m_run;
  bit m_hist[WN];
  bit m_dig, m_rl;
  int m_hl;

  ones_density_los u_ones_density_los (
    .clk(clk), .rst(rst), .pos_in(pos_in), .neg_in(neg_in),
    .analog_los(analog_los), .digital_los(digital_los), .rlos(rlos)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  initial begin
    wait (cyc > 200000);
    errors++;
    $display("FAIL watchdog: run hung, actual cycles=%0d expected<200000", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int hist_ones();
    int n = 0;
    for (int i = 0; i < WN; i++) if (m_hist[i]) n++;
    return n;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    m_run = 0; m_dig = 0; m_rl = 0; m_hl = 0;
    for (int i = 0; i < WN; i++) m_hist[i] = 0;
  endtask

  // one rising edge of the reference model
  task automatic model_edge(bit b, bit a);
    bit raw;
    raw = m_dig | a;
    if (!m_rl) begin
      if (raw) begin m_rl = 1; m_hl = 1; end
    end else begin
      if (m_hl >= MW && !raw) begin m_rl = 0; m_hl = 0; end
      else if (m_hl < MW) m_hl++;
    end
    m_run = b ? 0 : ((m_run >= ZT) ? ZT : m_run + 1);
    for (int i = WN - 1; i > 0; i--) m_hist[i] = m_hist[i-1];
    m_hist[0] = b;
    if (m_dig) m_dig = !(hist_ones() >= OC);
    else       m_dig = (m_run >= ZT);
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic step(bit p, bit n, bit a);
    pos_in = p; neg_in = n; analog_los = a;
    model_edge(p | n, a);
    @(negedge clk);
    chk("R2 digital_los vs model", digital_los, m_dig);
    chk("R5 rlos vs model", rlos, m_rl);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();
    chk("R7 digital_los after reset", digital_los, 1'b0);
    chk("R7 rlos after reset", rlos, 1'b0);

    // R3 / R1: a negative-rail one splits two near-threshold runs
    repeat (ZT - 1) step(0, 0, 0);
    step(0, 1, 0);
    repeat (ZT - 1) step(0, 0, 0);
    chk("R3 run restarted by neg-rail one", digital_los, 1'b0);
    step(0, 0, 0);
    chk("R2 alarm on exact threshold zero", digital_los, 1'b1);
    chk("R5 rlos one edge behind", rlos, 1'b0);
    step(0, 0, 0);
    chk("R5 rlos follows digital alarm", rlos, 1'b1);

    // R4: nine ones in the window keep the alarm, the tenth clears it
    repeat (9) step(1, 0, 0);
    repeat (30) step(0, 0, 0);
    chk("R4 sparse ones keep alarm", digital_los, 1'b1);
    repeat (9) step(1, 1, 0);
    chk("R4 nine ones in window keep alarm", digital_los, 1'b1);
    step(1, 1, 0);
    chk("R4 tenth one clears alarm (R1 both rails)", digital_los, 1'b0);

    // R8: long silence, counter saturates
    repeat (2000) step(0, 0, 0);
    chk("R8 alarm held through 2000 zeros", digital_los, 1'b1);
    repeat (10) step(0, 1, 0);
    chk("R4 alarm cleared after silence", digital_los, 1'b0);
    repeat (40) step(1, 0, 0);
    chk("R6 rlos released before pulse test", rlos, 1'b0);

    // R6: single-cycle analog pulse gives exactly MW high cycles
    step(1, 0, 1);
    chk("R5 rlos follows analog input", rlos, 1'b1);
    repeat (MW - 1) step(1, 0, 0);
    chk("R6 rlos still high at last held cycle", rlos, 1'b1);
    step(1, 0, 0);
    chk("R6 rlos drops after minimum width", rlos, 1'b0);

    // R5: long analog level, release drops rlos one edge later
    repeat (50) step(0, 1, 1);
    chk("R5 rlos high during analog level", rlos, 1'b1);
    step(0, 1, 0);
    chk("R5 rlos drops after analog release", rlos, 1'b0);

    // random phase with varied density
    for (int blk = 0; blk < 300; blk++) begin
      int dens = $urandom_range(0, 5);
      for (int k = 0; k < 64; k++) begin
        bit b, p, n, a;
        case (dens)
          0: b = 0;
          1: b = ($urandom_range(0, 39) == 0);
          2: b = ($urandom_range(0, 3) == 0);
          3: b = ($urandom_range(0, 9) < 3);
          default: b = $urandom_range(0, 1);
        endcase
        p = b && $urandom_range(0, 1);
        n = b && (!p || ($urandom_range(0, 7) == 0));
        a = ($urandom_range(0, 299) == 0);
        step(p, n, a);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule